// File: doc/BRIEF.md
# Write-Protect Command Guard

This block sits between the external byte-load bus and the sector load logic of a flash-style memory. It decides whether byte-load writes may program the array. Each write strobe is sampled on the system clock. Strobes that are too short are dropped. Writes are refused while the supply is not good, during a settling delay after the supply becomes good, and while a program cycle is running. Writes that pass these gates are grouped into a load session. The session closes when no further write arrives within a programmable window, and closing it starts the busy period of a program cycle.

A three-write unlock code, with fixed addresses and data values set by parameters, turns on a persistent protection flag. A variant of the code, whose third write carries different data, turns the flag off. While the flag is set, only a session that opens with the unlock code forwards its data. A session without the code forwards nothing, but it still starts the busy period. Code writes are never forwarded. The flag lives in its own reset domain: the functional reset leaves it alone, and only the power-on reset clears it.

Top module: `wp_cmd_guard`

## Requirements
- R1: After power-on reset, protect_o, busy_o, load_valid_o and prog_start_o are all 0.
- R2: With protection off, each accepted write that is not part of a code appears on load_valid_o, load_addr_o and load_data_o with the address held at strobe start and the data held at strobe end.
- R3: The writes (CMD_A1,CMD_D1), (CMD_A2,CMD_D2), (CMD_A3,CMD_D3), in that order within one session, set protect_o. None of the three is forwarded. Defaults: 5555h/AAh, 2AAAh/55h, 5555h/A0h.
- R4: While protection is on, data writes are forwarded only in a session that began with the R3 code. The R3 code re-arms forwarding for the rest of that session only.
- R5: A session with protection on and no code forwards nothing, yet its end still pulses prog_start_o and raises busy_o.
- R6: The writes (CMD_A1,CMD_D1), (CMD_A2,CMD_D2), (CMD_A3,DIS_D3) clear protect_o. None of them is forwarded, and later writes in the same session are forwarded. Default DIS_D3 is 20h.
- R7: A write that does not match the expected step in the middle of a code returns the detector to idle. That write is handled as an ordinary data write, and the earlier code writes are dropped.
- R8: protect_o keeps its value through rst_ni and is cleared only by por_ni.
- R9: LOAD_WIN cycles after the last accepted write, prog_start_o pulses for one cycle and busy_o stays high for PROG_CYC cycles.
- R10: Writes that arrive while busy_o is high are ignored. They forward nothing and open no session.
- R11: Writes are ignored while vcc_ok_i is low and for PWRUP_CYC cycles after it rises.
- R12: A write is recognised only when ce_ni and we_ni are low and oe_ni is high for at least MIN_PULSE consecutive clock edges. A shorter pulse, or a pulse made with oe_ni low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low async functional reset |
| por_ni | input | 1 | Active-low power-on reset for the protection flag |
| vcc_ok_i | input | 1 | Supply-good sense |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte-load address |
| data_i | input | DATA_W | Byte-load data |
| load_valid_o | output | 1 | One-cycle pulse for a forwarded load |
| load_addr_o | output | ADDR_W | Forwarded load address |
| load_data_o | output | DATA_W | Forwarded load data |
| prog_start_o | output | 1 | One-cycle pulse when a session closes |
| busy_o | output | 1 | Program cycle in progress |
| protect_o | output | 1 | Persistent protection flag |

## Verification
The detector is driven with plain loads, with complete enable and disable codes followed by data, and with sessions that carry no code under protection. This separates forwarding from suppression and shows that the busy timer starts even when nothing is stored. Codes broken after one and after two steps check that the aborting write falls back to being ordinary data, and that it is gated by the protection flag. Short strobes, strobes made with oe_ni low, writes during busy, and writes during supply-low or the settling delay must all leave the load outputs idle. A functional reset applied while protection is on shows which reset domain owns the flag.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2
  } seq_st_e;

  localparam int unsigned CODE_STEPS = 3;
endpackage

// File: rtl/wp_strobe_filter.sv
module wp_strobe_filter #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 2);

  logic              raw;
  logic              act_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_data_q;
  logic              wr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [DATA_W-1:0] wr_data_q;

  // oe low or either enable high blocks the strobe
  assign raw = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      cnt_q      <= '0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      wr_q       <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      act_q <= raw;
      wr_q  <= act_q & ~raw & (cnt_q >= CW'(MIN_PULSE));
      if (raw && !act_q) begin
        cnt_q      <= CW'(1);
        cap_addr_q <= addr_i;
      end else if (raw && (cnt_q < CW'(MIN_PULSE))) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (raw) cap_data_q <= data_i;
      if (act_q && !raw) begin
        wr_addr_q <= cap_addr_q;
        wr_data_q <= cap_data_q;
      end
    end
  end

  assign wr_o      = wr_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/wp_supply_guard.sv
module wp_supply_guard #(
  parameter int unsigned PWRUP_CYC = 625000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  output logic ok_o
);
  localparam int unsigned CW = $clog2(PWRUP_CYC + 2);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == CW'(PWRUP_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!vcc_ok_i) cnt_q <= '0;
    else if (!done)     cnt_q <= cnt_q + CW'(1);
  end

  assign ok_o = vcc_ok_i & done;
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_pkg::*;
#(
  parameter int unsigned       ADDR_W = 19,
  parameter int unsigned       DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMD_A1 = 'h5555,
  parameter logic [DATA_W-1:0] CMD_D1 = 'hAA,
  parameter logic [ADDR_W-1:0] CMD_A2 = 'h2AAA,
  parameter logic [DATA_W-1:0] CMD_D2 = 'h55,
  parameter logic [ADDR_W-1:0] CMD_A3 = 'h5555,
  parameter logic [DATA_W-1:0] CMD_D3 = 'hA0,
  parameter logic [DATA_W-1:0] DIS_D3 = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clear_i,
  output logic              load_valid_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              protect_o
);
  localparam logic [ADDR_W-1:0] STEP_A [CODE_STEPS] = '{CMD_A1, CMD_A2, CMD_A3};
  localparam logic [DATA_W-1:0] STEP_D [CODE_STEPS] = '{CMD_D1, CMD_D2, CMD_D3};

  logic [CODE_STEPS-1:0] hit;
  logic                  hit_dis;

  for (genvar i = 0; i < CODE_STEPS; i++) begin : g_step
    assign hit[i] = (addr_i == STEP_A[i]) && (data_i == STEP_D[i]);
  end
  assign hit_dis = (addr_i == CMD_A3) && (data_i == DIS_D3);

  seq_st_e     st_q, st_d;
  logic        code_q, code_d;
  logic        prot_q, prot_d;
  logic        is_data;
  logic        fwd;
  logic              lv_q;
  logic [ADDR_W-1:0] la_q;
  logic [DATA_W-1:0] ld_q;

  always_comb begin
    st_d    = st_q;
    code_d  = code_q;
    prot_d  = prot_q;
    is_data = 1'b0;
    if (clear_i) begin
      st_d   = ST_IDLE;
      code_d = 1'b0;
    end else if (wr_i) begin
      if (code_q) begin
        is_data = 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (hit[0]) st_d = ST_ONE;
            else        is_data = 1'b1;
          end
          ST_ONE: begin
            if (hit[1]) st_d = ST_TWO;
            else begin
              st_d    = ST_IDLE;
              is_data = 1'b1;
            end
          end
          ST_TWO: begin
            st_d = ST_IDLE;
            if (hit[2]) begin
              code_d = 1'b1;
              prot_d = 1'b1;
            end else if (hit_dis) begin
              code_d = 1'b1;
              prot_d = 1'b0;
            end else begin
              is_data = 1'b1;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  assign fwd = is_data & (~prot_q | code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= 1'b0;
      lv_q   <= 1'b0;
      la_q   <= '0;
      ld_q   <= '0;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
      lv_q   <= fwd;
      if (fwd) begin
        la_q <= addr_i;
        ld_q <= data_i;
      end
    end
  end

  // separate domain: functional reset leaves protection untouched
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) prot_q <= 1'b0;
    else         prot_q <= prot_d;
  end

  assign load_valid_o = lv_q;
  assign load_addr_o  = la_q;
  assign load_data_o  = ld_q;
  assign protect_o    = prot_q;
endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard #(
  parameter int unsigned       ADDR_W    = 19,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       MIN_PULSE = 2,
  parameter int unsigned       PWRUP_CYC = 625000,
  parameter int unsigned       LOAD_WIN  = 18750,
  parameter int unsigned       PROG_CYC  = 1250000,
  parameter logic [ADDR_W-1:0] CMD_A1    = 'h5555,
  parameter logic [DATA_W-1:0] CMD_D1    = 'hAA,
  parameter logic [ADDR_W-1:0] CMD_A2    = 'h2AAA,
  parameter logic [DATA_W-1:0] CMD_D2    = 'h55,
  parameter logic [ADDR_W-1:0] CMD_A3    = 'h5555,
  parameter logic [DATA_W-1:0] CMD_D3    = 'hA0,
  parameter logic [DATA_W-1:0] DIS_D3    = 'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              vcc_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              load_valid_o,
  output logic [ADDR_W-1:0] load_addr_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              prog_start_o,
  output logic              busy_o,
  output logic              protect_o
);
  localparam int unsigned WW = $clog2(LOAD_WIN + 2);
  localparam int unsigned BW = $clog2(PROG_CYC + 2);

  logic              wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              prog_ok;
  logic              acc;
  logic              sess_q;
  logic [WW-1:0]     win_q;
  logic              win_end;
  logic              sess_end;
  logic              busy_q;
  logic [BW-1:0]     bcnt_q;
  logic              start_q;

  wp_strobe_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
  ) u_strobe (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_o(wr), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  wp_supply_guard #(.PWRUP_CYC(PWRUP_CYC)) u_supply (
    .clk_i, .rst_ni, .vcc_ok_i, .ok_o(prog_ok)
  );

  assign acc      = wr & prog_ok & ~busy_q;
  assign win_end  = (win_q == WW'(LOAD_WIN - 1));
  assign sess_end = prog_ok & sess_q & ~acc & win_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sess_q  <= 1'b0;
      win_q   <= '0;
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (busy_q) begin
        if (bcnt_q == BW'(PROG_CYC - 1)) busy_q <= 1'b0;
        else                             bcnt_q <= bcnt_q + BW'(1);
      end
      if (!prog_ok) begin
        sess_q <= 1'b0;
        win_q  <= '0;
      end else if (acc) begin
        sess_q <= 1'b1;
        win_q  <= '0;
      end else if (sess_q) begin
        if (win_end) begin
          sess_q  <= 1'b0;
          start_q <= 1'b1;
          busy_q  <= 1'b1;
          bcnt_q  <= '0;
        end else begin
          win_q <= win_q + WW'(1);
        end
      end
    end
  end

  wp_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_A1(CMD_A1), .CMD_D1(CMD_D1), .CMD_A2(CMD_A2), .CMD_D2(CMD_D2),
    .CMD_A3(CMD_A3), .CMD_D3(CMD_D3), .DIS_D3(DIS_D3)
  ) u_seq (
    .clk_i, .rst_ni, .por_ni,
    .wr_i(acc), .addr_i(wr_addr), .data_i(wr_data),
    .clear_i(sess_end | ~prog_ok),
    .load_valid_o, .load_addr_o, .load_data_o, .protect_o
  );

  assign prog_start_o = start_q;
  assign busy_o       = busy_q;
endmodule

// File: rtl/wp_cmd_guard_chk.sv
module wp_cmd_guard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic vcc_ok_i,
  input logic acc_i,
  input logic load_valid_o,
  input logic prog_start_o,
  input logic busy_o,
  input logic protect_o
);
  a_r10_quiet_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_valid_o);

  a_r9_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> busy_o);

  a_r5_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> prog_start_o);

  a_r11_supply_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> !load_valid_o);

  a_r8_prot_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !acc_i |=> $stable(protect_o));
endmodule

bind wp_cmd_guard wp_cmd_guard_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .por_ni(por_ni), .vcc_ok_i(vcc_ok_i),
  .acc_i(acc), .load_valid_o(load_valid_o), .prog_start_o(prog_start_o),
  .busy_o(busy_o), .protect_o(protect_o)
);

// File: tb/sim_wp_cmd_guard.sv
`timescale 1ns/1ps
module sim_wp_cmd_guard;
  localparam int MP = 2, PU = 20, LW = 16, PC = 40;
  localparam int N = 20;

  function automatic logic [31:0] v(input bit e, input bit f, input bit p,
                                    input logic [4:0] r, input logic [15:0] a,
                                    input logic [7:0] d);
    return {e, f, p, r, a, d};
  endfunction

  // {session end, expect forward, expect protect, req, addr, data}
  localparam logic [31:0] VEC [N] = '{
    v(0,1,0,2,16'h0100,8'h11),  // R2
    v(1,1,0,2,16'h0101,8'h22),  // R2
    v(0,0,0,3,16'h5555,8'hAA),  // R3
    v(0,0,0,3,16'h2AAA,8'h55),  // R3
    v(0,0,1,3,16'h5555,8'hA0),  // R3
    v(1,1,1,4,16'h0200,8'h33),  // R4
    v(1,0,1,5,16'h0300,8'h44),  // R5
    v(0,0,1,7,16'h5555,8'hAA),  // R7
    v(1,0,1,7,16'h0400,8'h66),  // R7
    v(0,0,1,4,16'h5555,8'hAA),  // R4
    v(0,0,1,4,16'h2AAA,8'h55),  // R4
    v(0,0,1,4,16'h5555,8'hA0),  // R4
    v(1,1,1,4,16'h0500,8'h77),  // R4
    v(0,0,1,6,16'h5555,8'hAA),  // R6
    v(0,0,1,6,16'h2AAA,8'h55),  // R6
    v(0,0,0,6,16'h5555,8'h20),  // R6
    v(1,1,0,6,16'h0600,8'h88),  // R6
    v(0,0,0,7,16'h5555,8'hAA),  // R7
    v(0,0,0,7,16'h2AAA,8'h55),  // R7
    v(1,1,0,7,16'h1234,8'h99)   // R7
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0, vcc_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        load_valid, prog_start, busy, protect;
  logic [15:0] load_addr;
  logic [7:0]  load_data;

  int n_chk = 0, n_fail = 0, n_load = 0, n_start = 0;
  logic [15:0] last_a = '0;
  logic [7:0]  last_d = '0;
  bit done = 0;

  always #4 clk = ~clk;

  wp_cmd_guard #(
    .ADDR_W(16), .DATA_W(8), .MIN_PULSE(MP), .PWRUP_CYC(PU),
    .LOAD_WIN(LW), .PROG_CYC(PC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .vcc_ok_i(vcc_ok),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .data_i(data),
    .load_valid_o(load_valid), .load_addr_o(load_addr), .load_data_o(load_data),
    .prog_start_o(prog_start), .busy_o(busy), .protect_o(protect)
  );

  always @(negedge clk) begin
    if (load_valid) begin
      n_load++;
      last_a = load_addr;
      last_d = load_data;
    end
    if (prog_start) n_start++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int len);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int l0, s0;
    idle(2);
    rst_ni = 1'b1; por_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(protect == 1'b0, "R1", "protect", protect, 0);
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(load_valid == 1'b0 && prog_start == 1'b0, "R1", "load/start", load_valid, 0);
    idle(PU + 5);

    // R12 short strobe and oe-low strobe
    l0 = n_load; s0 = n_start;
    wr(16'h0700, 8'h5A, 1);
    idle(LW + 8);
    chk(n_load == l0 && n_start == s0, "R12", "short pulse loads", n_load - l0, 0);
    oe_n = 1'b0;
    wr(16'h0701, 8'h5B, 3);
    oe_n = 1'b1;
    idle(LW + 8);
    chk(n_load == l0 && n_start == s0, "R12", "oe low loads", n_load - l0, 0);

    for (int i = 0; i < N; i++) begin
      logic [31:0] e;
      string rq;
      e  = VEC[i];
      rq = $sformatf("R%0d", e[28:24]);
      l0 = n_load; s0 = n_start;
      wr(e[23:8], e[7:0], 3);
      chk((n_load - l0) == int'(e[30]), rq, $sformatf("vec %0d forwards", i), n_load - l0, e[30]);
      if (e[30])
        chk(last_a == e[23:8] && last_d == e[7:0], rq, $sformatf("vec %0d addr/data", i),
            {last_a, last_d}, e[23:0]);
      chk(protect == e[29], rq, $sformatf("vec %0d protect", i), protect, e[29]);
      if (e[31]) begin
        idle(LW + PC + 10);
        // R9 session close
        chk((n_start - s0) == 1 && !busy, "R9", $sformatf("vec %0d prog start", i), n_start - s0, 1);
      end
    end

    // R10 writes during busy
    l0 = n_load; s0 = n_start;
    wr(16'h0800, 8'h01, 3);
    idle(LW + 2);
    chk(busy == 1'b1, "R9", "busy after window", busy, 1);
    wr(16'h0801, 8'h02, 3);
    chk((n_load - l0) == 1, "R10", "load during busy", n_load - l0, 1);
    idle(PC + LW + 20);
    chk((n_start - s0) == 1, "R10", "sessions after busy write", n_start - s0, 1);

    // R11 supply low and settling delay
    l0 = n_load;
    vcc_ok = 1'b0;
    wr(16'h0900, 8'h03, 3);
    chk(n_load == l0, "R11", "load with supply low", n_load - l0, 0);
    vcc_ok = 1'b1;
    wr(16'h0901, 8'h04, 3);
    chk(n_load == l0, "R11", "load in settling delay", n_load - l0, 0);
    idle(PU + 5);
    wr(16'h0902, 8'h05, 3);
    chk((n_load - l0) == 1 && last_d == 8'h05, "R11", "load after delay", n_load - l0, 1);
    idle(LW + PC + 10);

    // R8 flag survives functional reset
    wr(16'h5555, 8'hAA, 3);
    wr(16'h2AAA, 8'h55, 3);
    wr(16'h5555, 8'hA0, 3);
    idle(LW + PC + 10);
    chk(protect == 1'b1, "R8", "protect set", protect, 1);
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(protect == 1'b1, "R8", "protect after rst_ni", protect, 1);
    idle(PU + 5);
    l0 = n_load;
    wr(16'h0A00, 8'h06, 3);
    chk(n_load == l0, "R8", "load blocked after rst_ni", n_load - l0, 0);
    idle(LW + PC + 10);
    por_ni = 1'b0;
    @(negedge clk);
    por_ni = 1'b1;
    @(negedge clk);
    chk(protect == 1'b0, "R8", "protect after por_ni", protect, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule